// File: doc/BRIEF.md
# Deferred Thread Run/Halt Evaluator

This block decides, for each hardware thread context of a multithreaded core, whether that thread runs or is halted. It does not act on every change of the thread-control bits. A write to any control register raises a pending flag. One cycle later a single evaluation recomputes the whole per-thread run vector from the current halt and activated bits. The vector then holds until the next evaluation.

Writes that arrive while an evaluation is already pending are absorbed into that evaluation. Only threads numbered up to the configured last-thread index take part. Higher threads are held stopped.

A small two-state controller sequences the work:
- **ST_IDLE**: no evaluation is owed. A write takes the transition *arm* to ST_ARMED.
- **ST_ARMED**: an evaluation is owed. On the next clock edge the transition *fire* always returns to ST_IDLE, whether or not another write is present. At that same edge the run vector is loaded and the done strobe is raised for one cycle.

Top module: `thread_run_eval`

## Requirements
- R1: While reset is asserted and immediately after it, `run_vec` is 1 (thread 0 running, all others stopped), `eval_done` is 0 and the controller is in ST_IDLE.
- R2: A `cr_write` sampled in ST_IDLE at clock edge k produces no output change at edge k. The evaluation fires at edge k+1, so `eval_done` is 1 during the cycle after edge k+1.
- R3: At the firing edge, bit i of `run_vec` becomes 1 exactly when `tc_halt[i]` is 0 and `tc_active[i]` is 1, for every thread i not above `cfg_last_tc`.
- R4: At the firing edge, every bit i of `run_vec` with i greater than `cfg_last_tc` becomes 0, whatever its halt and activated bits.
- R5: A `cr_write` sampled in ST_ARMED is absorbed and does not re-arm. A burst of L back-to-back write cycles starting from ST_IDLE yields exactly ceil(L/2) evaluations.
- R6: The evaluation samples the halt, activated and last-thread inputs present at the firing edge. It does not use those present at the arming write.
- R7: `eval_done` is high for exactly one cycle per evaluation and is never high in two consecutive cycles.
- R8: Between evaluations `run_vec` holds its value, even when the halt, activated and last-thread inputs change.
- R9: A `cfg_last_tc` value at or above the thread count makes every thread take part in the evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_write | input | 1 | One-cycle pulse: some control register was written |
| tc_halt | input | NUM_TC | Per-thread halt request bit |
| tc_active | input | NUM_TC | Per-thread activated bit |
| cfg_last_tc | input | CFG_W | Index of the last existing thread (thread count minus one) |
| run_vec | output | NUM_TC | Per-thread run decision, 1 = run |
| eval_done | output | 1 | One-cycle strobe in the cycle `run_vec` was refreshed |

## Verification
The controller state can be wrong in two ways, and the ports show both. A stuck ST_ARMED would make `eval_done` pulse on consecutive cycles or repeat without writes. A lost arm shows up as a missing strobe two cycles after a write. Wrong per-thread gating or masking appears in `run_vec` in the very cycle of the strobe. A sweep over every combination of halt, activated and last-thread index for four threads therefore exposes it at once. The sweep also checks that a vector, once loaded, never moves outside a strobe cycle.

// File: rtl/thread_run_eval_pkg.sv
package thread_run_eval_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } eval_state_e;

    // Thread 0 comes out of reset running; every other context is stopped.
    function automatic logic [63:0] reset_run_pattern();
        return 64'd1;
    endfunction

endpackage

// File: rtl/thread_run_arm.sv
module thread_run_arm
    import thread_run_eval_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_seen,
    output logic fire,
    output logic armed
);

    eval_state_e state_q;
    eval_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_seen) state_d = ST_ARMED;  // arm
            ST_ARMED: state_d = ST_IDLE;                // fire (writes absorbed)
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fire  = 1'b0;
        armed = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin fire = 1'b0; armed = 1'b0; end
            ST_ARMED: begin fire = 1'b1; armed = 1'b1; end
            default:  begin fire = 1'b0; armed = 1'b0; end
        endcase
    end

endmodule

// File: rtl/thread_run_mask.sv
module thread_run_mask #(
    parameter int NUM_TC = 4,
    parameter int CFG_W  = 3
) (
    input  logic [CFG_W-1:0]  last_tc,
    output logic [NUM_TC-1:0] present
);

    localparam int WIDE = (CFG_W > 32) ? CFG_W : 32;

    for (genvar g = 0; g < NUM_TC; g++) begin : g_tc
        localparam logic [WIDE-1:0] IDX = WIDE'(g);
        assign present[g] = (WIDE'(last_tc) >= IDX);
    end

endmodule

// File: rtl/thread_run_core.sv
module thread_run_core
    import thread_run_eval_pkg::*;
#(
    parameter int NUM_TC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [NUM_TC-1:0] halt,
    input  logic [NUM_TC-1:0] active,
    input  logic [NUM_TC-1:0] present,
    output logic [NUM_TC-1:0] run_q,
    output logic              done_q
);

    localparam logic [NUM_TC-1:0] RUN_RST = NUM_TC'(reset_run_pattern());

    logic [NUM_TC-1:0] run_d;

    for (genvar g = 0; g < NUM_TC; g++) begin : g_rule
        // halted when H=1 or A=0; runs only when present, H=0 and A=1
        assign run_d[g] = present[g] & ~halt[g] & active[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= RUN_RST;
            done_q <= 1'b0;
        end else begin
            done_q <= fire;
            if (fire) run_q <= run_d;
        end
    end

endmodule

// File: rtl/thread_run_eval.sv
module thread_run_eval #(
    parameter int NUM_TC = 4,
    parameter int CFG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_write,
    input  logic [NUM_TC-1:0] tc_halt,
    input  logic [NUM_TC-1:0] tc_active,
    input  logic [CFG_W-1:0]  cfg_last_tc,
    output logic [NUM_TC-1:0] run_vec,
    output logic              eval_done
);

    logic              fire;
    logic              armed;
    logic [NUM_TC-1:0] present;

    thread_run_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_seen (cr_write),
        .fire    (fire),
        .armed   (armed)
    );

    thread_run_mask #(.NUM_TC(NUM_TC), .CFG_W(CFG_W)) u_mask (
        .last_tc (cfg_last_tc),
        .present (present)
    );

    thread_run_core #(.NUM_TC(NUM_TC)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .halt    (tc_halt),
        .active  (tc_active),
        .present (present),
        .run_q   (run_vec),
        .done_q  (eval_done)
    );

endmodule

// File: rtl/thread_run_eval_chk.sv
module thread_run_eval_chk #(
    parameter int NUM_TC = 4,
    parameter int CFG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cr_write,
    input logic [NUM_TC-1:0] tc_halt,
    input logic [NUM_TC-1:0] tc_active,
    input logic [CFG_W-1:0]  cfg_last_tc,
    input logic [NUM_TC-1:0] run_vec,
    input logic              eval_done,
    input logic              armed
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic [NUM_TC-1:0] exist_mask(input logic [CFG_W-1:0] lt);
        logic [NUM_TC-1:0] m;
        for (int i = 0; i < NUM_TC; i++) m[i] = (int'(lt) >= i);
        return m;
    endfunction

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_write && !armed) |=> armed);

    p_fire_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> eval_done);

    p_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && eval_done) |->
            (run_vec == ($past(~tc_halt & tc_active) & exist_mask($past(cfg_last_tc)))));

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && eval_done) |-> ((run_vec & ~exist_mask($past(cfg_last_tc))) == '0));

    p_absorb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> !armed);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eval_done |=> !eval_done);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !eval_done) |-> $stable(run_vec));

endmodule

bind thread_run_eval thread_run_eval_chk #(.NUM_TC(NUM_TC), .CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_write    (cr_write),
    .tc_halt     (tc_halt),
    .tc_active   (tc_active),
    .cfg_last_tc (cfg_last_tc),
    .run_vec     (run_vec),
    .eval_done   (eval_done),
    .armed       (armed)
);

// File: tb/thread_run_eval_test.sv
`timescale 1ns/1ps
module thread_run_eval_test;

    localparam int NUM_TC = 4;
    localparam int CFG_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cr_write = 1'b0;
    logic [NUM_TC-1:0] tc_halt = '0;
    logic [NUM_TC-1:0] tc_active = '1;
    logic [CFG_W-1:0]  cfg_last_tc = '0;
    logic [NUM_TC-1:0] run_vec;
    logic              eval_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    thread_run_eval #(.NUM_TC(NUM_TC), .CFG_W(CFG_W)) uut (
        .clk(clk), .rst_n(rst_n), .cr_write(cr_write),
        .tc_halt(tc_halt), .tc_active(tc_active), .cfg_last_tc(cfg_last_tc),
        .run_vec(run_vec), .eval_done(eval_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NUM_TC-1:0] expect_run(input logic [NUM_TC-1:0] h,
            input logic [NUM_TC-1:0] a, input int lt);
        logic [NUM_TC-1:0] r;
        for (int i = 0; i < NUM_TC; i++) r[i] = (i <= lt) && !h[i] && a[i];
        return r;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [NUM_TC-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 run during reset", 32'(run_vec), 32'd1);
        chk("R1 done during reset", 32'(eval_done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 run after reset", 32'(run_vec), 32'd1);
        chk("R1 done after reset", 32'(eval_done), 32'd0);

        // R2 R3 R4 R9: full sweep
        for (int lt = 0; lt < (1 << CFG_W); lt++) begin
            for (int h = 0; h < (1 << NUM_TC); h++) begin
                for (int a = 0; a < (1 << NUM_TC); a++) begin
                    held = run_vec;
                    tc_halt = NUM_TC'(h);
                    tc_active = NUM_TC'(a);
                    cfg_last_tc = CFG_W'(lt);
                    cr_write = 1'b1;
                    @(negedge clk);
                    cr_write = 1'b0;
                    chk("R2 no done at arm edge", 32'(eval_done), 32'd0);
                    chk("R2 run unchanged at arm edge", 32'(run_vec), 32'(held));
                    @(negedge clk);
                    chk("R2 done after fire", 32'(eval_done), 32'd1);
                    chk("R3 R4 R9 run vector", 32'(run_vec),
                        32'(expect_run(NUM_TC'(h), NUM_TC'(a), lt)));
                    @(negedge clk);
                    chk("R7 done single cycle", 32'(eval_done), 32'd0);
                end
            end
        end

        // R5: bursts coalesce
        for (int len = 1; len <= 7; len++) begin
            int pulses;
            pulses = 0;
            for (int k = 0; k < len + 4; k++) begin
                if (eval_done) pulses++;
                cr_write = (k < len);
                @(negedge clk);
            end
            cr_write = 1'b0;
            chk("R5 burst evaluations", 32'(pulses), 32'((len + 1) / 2));
        end

        // R6: inputs at firing edge used; write in armed cycle absorbed (R5)
        tc_halt = '1; tc_active = '1; cfg_last_tc = 3'd3;
        cr_write = 1'b1;
        @(negedge clk);
        chk("R2 armed no done", 32'(eval_done), 32'd0);
        tc_halt = '0; tc_active = 4'b1011; cr_write = 1'b1;
        @(negedge clk);
        cr_write = 1'b0;
        chk("R6 done", 32'(eval_done), 32'd1);
        chk("R6 firing-edge inputs", 32'(run_vec), 32'h0B);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 absorbed write no re-arm", 32'(eval_done), 32'd0);
        end

        // R8: hold without writes
        held = run_vec;
        for (int k = 0; k < 6; k++) begin
            tc_halt = NUM_TC'(k * 5);
            tc_active = NUM_TC'(~k);
            cfg_last_tc = CFG_W'(k);
            @(negedge clk);
            chk("R8 run held", 32'(run_vec), 32'(held));
            chk("R8 no done", 32'(eval_done), 32'd0);
        end

        finish_run();
    end

endmodule